// File: doc/BRIEF.md
# Three-Phase Complementary Triangle PWM with Dead Time

This block drives three complementary output pairs, one pair per motor phase, from one shared triangle counter. The counter climbs from zero to a programmed period and falls back to zero. Each phase compares the counter against its own duty value. The high side of a pair is on near the top of the triangle, and the low side is on near the bottom. The dead-time value moves both thresholds away from the duty value, one upward and one downward, so each pair always has an idle gap between the two sides.

Software writes the new duty values into per-phase buffer registers. The active duty values take these buffers only when the counter is at zero, so a period always completes with one consistent set of thresholds. An external clear input restarts the triangle. An emergency trip input turns every output off in the same cycle, without waiting for a clock edge. The trip is also held in a latch until software clears it. Each time the counter reaches its peak, the block flips a toggle output and sends a one-cycle start pulse to an analog-to-digital converter.

The period value must be at least 1. The reset input is asynchronous when it asserts. Its release passes through a two-stage synchroniser.

Top module: `tri_pwm3`

## Requirements
- R1: While reset is applied, the counter is 0 and counting up, the toggle and ADC outputs are 0, and every buffer and duty value is 0.
- R2: With `run_i` high, the counter steps by one per clock from 0 up to `per_i` and then back down to 0. It turns around as soon as it reaches or exceeds `per_i` while counting up, and its next value is one lower. At 0 while counting down, its next value is 1.
- R3: A write with `wr_en_i[p]` high loads `wr_data_i` into the buffer of phase p. The duty value of phase p copies that buffer only on a clock edge where the counter is 0, so a write made in the middle of a period has no effect on the outputs until the counter has passed 0.
- R4: `hi_o[p]` is 1 while the counter is greater than or equal to duty + dead time.
- R5: `lo_o[p]` is 1 while the counter is less than duty − dead time.
- R6: When duty + 2×dead time exceeds `per_i`, `hi_o[p]` stays 0. When duty is less than 2×dead time, `lo_o[p]` stays 0.
- R7: `hi_o[p]` and `lo_o[p]` are never 1 together.
- R8: `tgl_o` inverts on each clock edge where the counter turns around at the peak.
- R9: `adc_trig_o` is 1 for exactly the one cycle after each peak turnaround, and it is 0 at all other times.
- R10: `clr_i` high forces the counter to 0 and counting up on the next edge. It takes priority over `run_i`.
- R11: `trip_i` high forces all six outputs to 0 within the same cycle. A clock edge with `trip_i` high sets a latch that keeps the outputs at 0 until `trip_clr_i` is seen high while `trip_i` is low.
- R12: With `run_i` low and `clr_i` low, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_i | input | 1 | Counter enable |
| clr_i | input | 1 | External counter clear |
| per_i | input | CW | Triangle peak value (at least 1) |
| dt_i | input | CW | Dead-time offset |
| wr_en_i | input | NPH | Per-phase buffer write strobe |
| wr_data_i | input | CW | Buffer write data |
| trip_i | input | 1 | Emergency output-off |
| trip_clr_i | input | 1 | Clears the trip latch |
| hi_o | output | NPH | High-side outputs |
| lo_o | output | NPH | Low-side outputs |
| cnt_o | output | CW | Triangle counter value |
| tgl_o | output | 1 | Toggles at each peak |
| adc_trig_o | output | 1 | One-cycle ADC start pulse |

## Verification
The counter, the toggle, the ADC pulse and the trip latch change on the first rising edge after their cause. The side outputs follow the counter and duty registers in the same cycle, so every one of these results is due one edge after the stimulus. Inputs change just after a falling edge. A reference model advances on each rising edge, and the scoreboard compares its prediction at the next falling edge. The trip input is the one result that does not wait for an edge, so it is checked a nanosecond after it is driven. The first edge-driven results appear two edges after reset is released, because of the reset synchroniser.

// File: rtl/tri_pwm3_pkg.sv
package tri_pwm3_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;
endpackage

// File: rtl/tri_pwm3_cnt.sv
module tri_pwm3_cnt
  import tri_pwm3_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          valley_o,
  output logic          peak_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  dir_e          dir_q, dir_d;

  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    peak_o = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (run_i) begin
      if (dir_q == DIR_UP) begin
        if (cnt_q >= per_i) begin
          peak_o = 1'b1;
          dir_d  = DIR_DN;
          cnt_d  = cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        dir_d = DIR_UP;
        cnt_d = {{(CW-1){1'b0}}, 1'b1};
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign valley_o = (cnt_q == '0);
endmodule

// File: rtl/tri_pwm3_phase.sv
module tri_pwm3_phase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] dt_i,
  input  logic [CW-1:0] per_i,
  output logic          hi_raw_o,
  output logic          lo_raw_o
);
  localparam int EW = CW + 2;

  logic [CW-1:0] buf_q, buf_d, duty_q, duty_d;
  logic [EW-1:0] duty_x, dt_x, cnt_x, per_x;
  logic          hi_en, lo_en;

  always_comb begin
    buf_d  = wr_en_i ? wr_data_i : buf_q;
    duty_d = load_i  ? buf_q     : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      duty_q <= '0;
    end else begin
      buf_q  <= buf_d;
      duty_q <= duty_d;
    end
  end

  assign duty_x = {2'b00, duty_q};
  assign dt_x   = {2'b00, dt_i};
  assign cnt_x  = {2'b00, cnt_i};
  assign per_x  = {2'b00, per_i};

  // a side whose window would be narrower than two dead times is held off
  assign hi_en    = (duty_x + (dt_x << 1)) <= per_x;
  assign lo_en    = duty_x >= (dt_x << 1);
  assign hi_raw_o = hi_en && (cnt_x >= (duty_x + dt_x));
  assign lo_raw_o = lo_en && (cnt_x < (duty_x - dt_x));
endmodule

// File: rtl/tri_pwm3.sv
module tri_pwm3 #(
  parameter int CW  = 8,
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           clr_i,
  input  logic [CW-1:0]  per_i,
  input  logic [CW-1:0]  dt_i,
  input  logic [NPH-1:0] wr_en_i,
  input  logic [CW-1:0]  wr_data_i,
  input  logic           trip_i,
  input  logic           trip_clr_i,
  output logic [NPH-1:0] hi_o,
  output logic [NPH-1:0] lo_o,
  output logic [CW-1:0]  cnt_o,
  output logic           tgl_o,
  output logic           adc_trig_o
);
  logic [1:0]     rst_sync_q;
  logic           rst_s;
  logic           valley, peak;
  logic [NPH-1:0] hi_raw, lo_raw;
  logic           trip_lat_q, trip_lat_d;
  logic           tgl_q, tgl_d, adc_q, adc_d;
  logic           out_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  tri_pwm3_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s),
    .run_i    (run_i),
    .clr_i    (clr_i),
    .per_i    (per_i),
    .cnt_o    (cnt_o),
    .valley_o (valley),
    .peak_o   (peak)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    tri_pwm3_phase #(.CW(CW)) u_phase (
      .clk       (clk),
      .rst_n     (rst_s),
      .wr_en_i   (wr_en_i[p]),
      .wr_data_i (wr_data_i),
      .load_i    (valley),
      .cnt_i     (cnt_o),
      .dt_i      (dt_i),
      .per_i     (per_i),
      .hi_raw_o  (hi_raw[p]),
      .lo_raw_o  (lo_raw[p])
    );
  end

  always_comb begin
    trip_lat_d = trip_lat_q;
    if (trip_i)          trip_lat_d = 1'b1;
    else if (trip_clr_i) trip_lat_d = 1'b0;
    tgl_d = tgl_q ^ peak;
    adc_d = peak;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      trip_lat_q <= 1'b0;
      tgl_q      <= 1'b0;
      adc_q      <= 1'b0;
    end else begin
      trip_lat_q <= trip_lat_d;
      tgl_q      <= tgl_d;
      adc_q      <= adc_d;
    end
  end

  assign out_off    = trip_i | trip_lat_q;
  assign hi_o       = out_off ? '0 : hi_raw;
  assign lo_o       = out_off ? '0 : lo_raw;
  assign tgl_o      = tgl_q;
  assign adc_trig_o = adc_q;
endmodule

// File: rtl/tri_pwm3_chk.sv
module tri_pwm3_chk #(
  parameter int CW  = 8,
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_s,
  input logic           run_i,
  input logic           clr_i,
  input logic           trip_i,
  input logic [NPH-1:0] hi_o,
  input logic [NPH-1:0] lo_o,
  input logic [CW-1:0]  cnt_o,
  input logic           tgl_o,
  input logic           adc_trig_o
);
  assert_pair_excl_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (hi_o & lo_o) == '0);

  assert_trip_now_R11: assert property (@(posedge clk) disable iff (!rst_s)
    trip_i |-> (hi_o == '0 && lo_o == '0));

  assert_trip_held_R11: assert property (@(posedge clk) disable iff (!rst_s)
    trip_i |=> (hi_o == '0 && lo_o == '0));

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (run_i && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == $past(cnt_o) - 1'b1));

  assert_clr_zero_R10: assert property (@(posedge clk) disable iff (!rst_s)
    clr_i |=> cnt_o == '0);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_s)
    (!run_i && !clr_i) |=> $stable(cnt_o));

  assert_adc_single_R9: assert property (@(posedge clk) disable iff (!rst_s)
    adc_trig_o |=> !adc_trig_o);

  assert_tgl_with_adc_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (tgl_o != $past(tgl_o)) == adc_trig_o);
endmodule

bind tri_pwm3 tri_pwm3_chk #(.CW(CW), .NPH(NPH)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .run_i      (run_i),
  .clr_i      (clr_i),
  .trip_i     (trip_i),
  .hi_o       (hi_o),
  .lo_o       (lo_o),
  .cnt_o      (cnt_o),
  .tgl_o      (tgl_o),
  .adc_trig_o (adc_trig_o)
);

// File: tb/tri_pwm3_test.sv
module tri_pwm3_test;
  localparam int CW  = 8;
  localparam int NPH = 3;

  logic           clk, rst_n, run_i, clr_i, trip_i, trip_clr_i;
  logic [CW-1:0]  per_i, dt_i, wr_data_i;
  logic [NPH-1:0] wr_en_i;
  logic [NPH-1:0] hi_o, lo_o;
  logic [CW-1:0]  cnt_o;
  logic           tgl_o, adc_trig_o;

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;

  tri_pwm3 #(.CW(CW), .NPH(NPH)) uut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .clr_i(clr_i),
    .per_i(per_i), .dt_i(dt_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .trip_i(trip_i), .trip_clr_i(trip_clr_i), .hi_o(hi_o), .lo_o(lo_o),
    .cnt_o(cnt_o), .tgl_o(tgl_o), .adc_trig_o(adc_trig_o)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  logic [1:0] m_sync;
  int m_cnt, m_buf[NPH], m_duty[NPH];
  bit m_dn, m_tgl, m_adc, m_lat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_sync <= 2'b00;
    else        m_sync <= {m_sync[0], 1'b1};
  end

  always @(posedge clk or negedge rst_n) begin : model
    bit pk;
    if (!rst_n || !m_sync[1]) begin
      m_cnt <= 0; m_dn <= 0; m_tgl <= 0; m_adc <= 0; m_lat <= 0;
      for (int p = 0; p < NPH; p++) begin m_buf[p] <= 0; m_duty[p] <= 0; end
    end else begin
      pk = 0;
      for (int p = 0; p < NPH; p++) begin
        if (m_cnt == 0) m_duty[p] <= m_buf[p];
        if (wr_en_i[p]) m_buf[p] <= int'(wr_data_i);
      end
      if (clr_i) begin
        m_cnt <= 0; m_dn <= 0;
      end else if (run_i) begin
        if (!m_dn) begin
          if (m_cnt >= int'(per_i)) begin pk = 1; m_dn <= 1; m_cnt <= m_cnt - 1; end
          else m_cnt <= m_cnt + 1;
        end else if (m_cnt == 0) begin
          m_dn <= 0; m_cnt <= 1;
        end else m_cnt <= m_cnt - 1;
      end
      m_tgl <= m_tgl ^ pk;
      m_adc <= pk;
      if (trip_i) m_lat <= 1;
      else if (trip_clr_i) m_lat <= 0;
    end
  end

  typedef struct {
    int cnt;
    logic [NPH-1:0] hi, lo;
    bit tgl, adc;
  } exp_t;
  exp_t sb_q[$];

  task automatic predict();
    exp_t e;
    bit off;
    int dt, per;
    off = trip_i | m_lat;
    dt  = int'(dt_i);
    per = int'(per_i);
    e.cnt = m_cnt; e.tgl = m_tgl; e.adc = m_adc;
    for (int p = 0; p < NPH; p++) begin
      e.hi[p] = !off && (m_duty[p] + 2*dt <= per) && (m_cnt >= m_duty[p] + dt);
      e.lo[p] = !off && (m_duty[p] >= 2*dt) && (m_cnt < m_duty[p] - dt);
    end
    sb_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      predict();
      e = sb_q.pop_front();
      chk(int'(cnt_o) == e.cnt, "R2 R10 R12 counter", int'(cnt_o), e.cnt);
      chk(hi_o == e.hi, "R4 R6 R3 high side", int'(hi_o), int'(e.hi));
      chk(lo_o == e.lo, "R5 R6 R3 low side", int'(lo_o), int'(e.lo));
      chk((hi_o & lo_o) == '0, "R7 pair overlap", int'(hi_o & lo_o), 0);
      chk(tgl_o == e.tgl, "R8 toggle", int'(tgl_o), int'(e.tgl));
      chk(adc_trig_o == e.adc, "R9 adc pulse", int'(adc_trig_o), int'(e.adc));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int p, int val);
    step(1);
    wr_en_i   = NPH'(1) << p;
    wr_data_i = CW'(val);
    step(1);
    wr_en_i = '0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_i = 1'b0; clr_i = 1'b0; trip_i = 1'b0; trip_clr_i = 1'b0;
    per_i = 8'd20; dt_i = 8'd2; wr_en_i = '0; wr_data_i = '0;
    step(3);
    chk(cnt_o == '0, "R1 reset counter", int'(cnt_o), 0);
    chk(tgl_o == 1'b0, "R1 reset toggle", int'(tgl_o), 0);
    chk(adc_trig_o == 1'b0, "R1 reset adc", int'(adc_trig_o), 0);
    rst_n = 1'b1;
    step(4);
    mon_on = 1'b1;
    // hi boundary on phase 1 (16+4=20), lo boundary on phase 2 (4=2*2)
    wr(0, 10); wr(1, 16); wr(2, 4);
    run_i = 1'b1;
    step(90);
    // mid-period writes: hi clamp, lo clamp, lo off
    wr(0, 17); wr(1, 3); wr(2, 0);
    step(90);
    run_i = 1'b0;
    step(8);
    run_i = 1'b1;
    step(15);
    clr_i = 1'b1;
    step(1);
    clr_i = 1'b0;
    step(30);
    trip_i = 1'b1;
    #1;
    chk(hi_o == '0 && lo_o == '0, "R11 immediate off", int'({hi_o, lo_o}), 0);
    step(3);
    trip_i = 1'b0;
    step(4);
    chk(hi_o == '0 && lo_o == '0, "R11 latched off", int'({hi_o, lo_o}), 0);
    trip_clr_i = 1'b1;
    step(1);
    trip_clr_i = 1'b0;
    step(30);
    dt_i = 8'd0;
    wr(0, 20); wr(1, 0);
    step(90);
    per_i = 8'd6; dt_i = 8'd1;
    wr(0, 2); wr(1, 3); wr(2, 4);
    step(40);
    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule